// File: doc/BRIEF.md
# Scoped Operand Alias Table

This block sits beside an instruction issue stage and watches the 64-bit instruction stream for alias instructions. Each one records a mapping in one of three independent tables, chosen by a scope code: texture, render target or memory. The mapping goes from a destination register number to a replacement operand. That operand is a general-register number, a constant-register index or an immediate. The issue stage asks for a later source-register read by giving a scope and a register number. The block answers in the same cycle with a hit flag, the replacement value, its source kind and whether the value is a 16-bit half.

Texture and memory tables are bounded. The first alias written into an empty bounded table declares how many entries the group will hold. Entries past that count are dropped and reported. The render-target table is bounded only by its physical depth. It keys on a 5-bit target/component code and refuses general-register sources. A synchronous clear empties every table at the start of a new program.

Top module: `operand_alias_table`

## Requirements
- R1: A word creates or changes an entry only when `inst_valid` is high, bits 63:61 are 111 and bits 58:55 are 1000. Any other word, or a valid alias word presented with `inst_valid` low, leaves every table and both flags unchanged.
- R2: The scope code is {bit 49, bit 47}. Code 0 selects the texture table, 1 the render-target table, and 2 and 3 both select the same memory table. A lookup uses the same encoding on `lk_scope`, and the tables do not see each other's entries.
- R3: Bits 52:51 give the source kind, reported on `lk_kind`. Kind 0 is a general register whose value is bits 7:0. Kind 1 is a constant register whose value is bits 10:0. Kinds 2 and 3 are immediates, reported as kind 2. All other value bits read as zero.
- R4: In the texture and memory scopes, bit 50 equal to 0 marks a half-size operand. `lk_half` is then 1 and an immediate keeps only bits 15:0. Bit 50 equal to 1 gives `lk_half` 0 and keeps all 32 immediate bits.
- R5: In render-target scope the key is bits 36:32, zero-extended to 8 bits. Bit 50 is ignored, so `lk_half` is 0 and immediates keep 32 bits. A general-register source writes nothing and raises `err_rt_src` for exactly one cycle.
- R6: In the texture and memory scopes the key is bits 39:32.
- R7: A lookup is combinational. A mapping captured at a clock edge is returned to a lookup in the cycle right after that edge, with no idle cycle.
- R8: When an alias with a new key reaches an empty texture or memory table, it sets that table's capacity to bits 43:40 plus one. A new key arriving when the capacity is already used is dropped and raises `ovf` for one cycle. The render-target table's capacity is its depth (16).
- R9: An alias whose key is already in its scope's table overwrites that entry. It uses no capacity and never raises `ovf`.
- R10: `clr` empties all three tables at the next edge and suppresses both flags. It takes priority over an alias presented in the same cycle.
- R11: On a miss, or whenever `lk_valid` is low, `lk_hit`, `lk_kind`, `lk_half` and `lk_value` are all zero. After reset every lookup misses and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all tables |
| inst_valid | input | 1 | An instruction word is presented this cycle |
| inst | input | 64 | Instruction word |
| lk_valid | input | 1 | Lookup request valid |
| lk_scope | input | 2 | Scope code of the reading instruction |
| lk_reg | input | 8 | Source register number being read |
| lk_hit | output | 1 | The register is aliased in that scope |
| lk_kind | output | 2 | Source kind of the replacement (0 GPR, 1 const, 2 immediate) |
| lk_half | output | 1 | Replacement is a 16-bit half operand |
| lk_value | output | 32 | Replacement register number, index or immediate |
| err_rt_src | output | 1 | One-cycle pulse: render-target alias with a GPR source was rejected |
| ovf | output | 1 | One-cycle pulse: an entry beyond the group capacity was dropped |

## Verification
The assertions check several rules on every cycle. An error pulse must trace back to a render-target alias with a GPR source. The two flags are never high together. The cycle after a clear never hits, and an idle lookup port reads all zeros. A render-target hit never reports a GPR source or a half operand, and half hits have a clear upper halfword. Other behaviour shows only in the bench's scenarios. These are capacity set by the first write of a group, dropping of the extra entry, in-place overwrite of a repeated key, masking of value fields and the sharing of one table by both memory codes. Each scenario is followed by a sweep over every scope code and the register range in use, checked against a model of the tables.

// File: rtl/oat_pkg.sv
package oat_pkg;

    localparam int INST_W  = 64;
    localparam int VAL_W   = 32;
    localparam int TAG_W   = 8;
    localparam int RTTAG_W = 5;
    localparam int NSCOPE  = 3;

    // instruction field positions the decoder relies on
    localparam int CLS_HI   = 63;
    localparam int CLS_LO   = 61;
    localparam int OPC_HI   = 58;
    localparam int OPC_LO   = 55;
    localparam int KIND_HI  = 52;
    localparam int KIND_LO  = 51;
    localparam int SIZE_B   = 50;
    localparam int SCHI_B   = 49;
    localparam int SCLO_B   = 47;
    localparam int CNT_HI   = 43;
    localparam int CNT_LO   = 40;
    localparam int DST_HI   = 39;
    localparam int DST_LO   = 32;

    localparam logic [2:0] CLS_CODE = 3'b111;
    localparam logic [3:0] OPC_CODE = 4'b1000;

    typedef enum logic [1:0] {
        SRC_GPR   = 2'd0,
        SRC_CONST = 2'd1,
        SRC_IMM   = 2'd2
    } src_kind_e;

    typedef enum logic [1:0] {
        SC_TEX = 2'd0,
        SC_RT  = 2'd1,
        SC_MEM = 2'd2
    } scope_e;

    typedef struct packed {
        src_kind_e        kind;
        logic             half;
        logic [VAL_W-1:0] value;
    } alias_val_t;

    typedef struct packed {
        logic             is_alias;
        scope_e           scope;
        logic [TAG_W-1:0] tag;
        logic [3:0]       size_m1;
        logic             rt_bad;
        alias_val_t       val;
    } alias_dec_t;

    // both upper codes fold onto the memory table
    function automatic scope_e scope_of(input logic [1:0] code);
        case (code)
            2'd0:    return SC_TEX;
            2'd1:    return SC_RT;
            default: return SC_MEM;
        endcase
    endfunction

    function automatic src_kind_e kind_of(input logic [1:0] code);
        case (code)
            2'd0:    return SRC_GPR;
            2'd1:    return SRC_CONST;
            default: return SRC_IMM;
        endcase
    endfunction

endpackage

// File: rtl/oat_decode.sv
module oat_decode
    import oat_pkg::*;
(
    input  logic [INST_W-1:0] inst,
    output alias_dec_t        dec
);

    logic      is_rt;
    logic      half;
    src_kind_e kind;

    always_comb begin
        dec          = '0;
        kind         = kind_of(inst[KIND_HI:KIND_LO]);
        dec.is_alias = (inst[CLS_HI:CLS_LO] == CLS_CODE) &&
                       (inst[OPC_HI:OPC_LO] == OPC_CODE);
        dec.scope    = scope_of({inst[SCHI_B], inst[SCLO_B]});
        is_rt        = (dec.scope == SC_RT);
        half         = !is_rt && !inst[SIZE_B];
        dec.size_m1  = inst[CNT_HI:CNT_LO];
        dec.tag      = is_rt ? TAG_W'(inst[DST_LO +: RTTAG_W])
                             : inst[DST_HI:DST_LO];
        dec.rt_bad   = is_rt && (kind == SRC_GPR);
        dec.val.kind = kind;
        dec.val.half = half;
        case (kind)
            SRC_GPR:   dec.val.value = VAL_W'(inst[7:0]);
            SRC_CONST: dec.val.value = VAL_W'(inst[10:0]);
            default:   dec.val.value = half ? VAL_W'(inst[15:0]) : inst[VAL_W-1:0];
        endcase
    end

endmodule

// File: rtl/oat_scope_table.sv
module oat_scope_table
    import oat_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter bit BOUNDED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  alias_val_t       wr_val,
    input  logic [3:0]       wr_size_m1,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output alias_val_t       rd_val,
    output logic             ovf
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    alias_val_t       val_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    logic             wr_match;
    logic [IDX_W-1:0] wr_match_idx;
    logic [4:0]       req;
    logic [CNT_W-1:0] lim_new;
    logic [CNT_W-1:0] lim_eff;
    logic             do_wr;
    logic             do_append;

    // read port: keys are unique, so at most one entry matches
    always_comb begin
        rd_hit = 1'b0;
        rd_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i] && tag_q[i] == rd_tag) begin
                rd_hit = 1'b1;
                rd_val = val_q[i];
            end
        end
    end

    // write-side match for in-place replacement
    always_comb begin
        wr_match     = 1'b0;
        wr_match_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i] && tag_q[i] == wr_tag) begin
                wr_match     = 1'b1;
                wr_match_idx = IDX_W'(i);
            end
        end
    end

    generate
        if (BOUNDED) begin : g_bounded
            always_comb begin
                req     = {1'b0, wr_size_m1} + 5'd1;
                lim_new = (int'(req) < DEPTH) ? CNT_W'(req) : DEPTH_C;
            end
        end else begin : g_open
            always_comb begin
                req     = '0;
                lim_new = DEPTH_C;
            end
        end
    endgenerate

    assign lim_eff   = (cnt_q == '0) ? lim_new : lim_q;
    assign do_wr     = wr_en && !clr;
    assign do_append = do_wr && !wr_match && (cnt_q < lim_eff);
    assign ovf       = do_wr && !wr_match && (cnt_q >= lim_eff);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                val_q[i] <= '0;
            end
            cnt_q <= '0;
            lim_q <= '0;
        end else if (do_wr) begin
            if (wr_match) begin
                val_q[wr_match_idx] <= wr_val;
            end else if (do_append) begin
                vld_q[cnt_q[IDX_W-1:0]] <= 1'b1;
                tag_q[cnt_q[IDX_W-1:0]] <= wr_tag;
                val_q[cnt_q[IDX_W-1:0]] <= wr_val;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '0) begin
                    lim_q <= lim_new;
                end
            end
        end
    end

endmodule

// File: rtl/operand_alias_table.sv
module operand_alias_table
    import oat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inst_valid,
    input  logic [INST_W-1:0] inst,
    input  logic              lk_valid,
    input  logic [1:0]        lk_scope,
    input  logic [TAG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic [1:0]        lk_kind,
    output logic              lk_half,
    output logic [VAL_W-1:0]  lk_value,
    output logic              err_rt_src,
    output logic              ovf
);

    alias_dec_t        dec;
    logic              take;
    logic [NSCOPE-1:0] tbl_hit;
    logic [NSCOPE-1:0] tbl_ovf;
    alias_val_t        tbl_val [NSCOPE];
    alias_val_t        sel_val;
    logic              sel_hit;
    scope_e            rd_scope;
    logic              err_q;
    logic              ovf_q;

    oat_decode u_dec (
        .inst (inst),
        .dec  (dec)
    );

    assign take = inst_valid && dec.is_alias && !dec.rt_bad;

    generate
        for (genvar s = 0; s < NSCOPE; s++) begin : g_scope
            oat_scope_table #(
                .DEPTH   (DEPTH),
                .BOUNDED (s != int'(SC_RT))
            ) u_tbl (
                .clk        (clk),
                .rst        (rst),
                .clr        (clr),
                .wr_en      (take && (int'(dec.scope) == s)),
                .wr_tag     (dec.tag),
                .wr_val     (dec.val),
                .wr_size_m1 (dec.size_m1),
                .rd_tag     (lk_reg),
                .rd_hit     (tbl_hit[s]),
                .rd_val     (tbl_val[s]),
                .ovf        (tbl_ovf[s])
            );
        end
    endgenerate

    always_comb begin
        rd_scope = scope_of(lk_scope);
        sel_hit  = lk_valid && tbl_hit[int'(rd_scope)];
        sel_val  = sel_hit ? tbl_val[int'(rd_scope)] : '0;
    end

    assign lk_hit   = sel_hit;
    assign lk_kind  = sel_val.kind;
    assign lk_half  = sel_val.half;
    assign lk_value = sel_val.value;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            err_q <= inst_valid && dec.is_alias && dec.rt_bad;
            ovf_q <= |tbl_ovf;
        end
    end

    assign err_rt_src = err_q;
    assign ovf        = ovf_q;

endmodule

// File: rtl/oat_checker.sv
module oat_checker (
    input logic        clk,
    input logic        rst,
    input logic        clr,
    input logic        inst_valid,
    input logic [63:0] inst,
    input logic        lk_valid,
    input logic [1:0]  lk_scope,
    input logic        lk_hit,
    input logic [1:0]  lk_kind,
    input logic        lk_half,
    input logic [31:0] lk_value,
    input logic        err_rt_src,
    input logic        ovf
);

    logic opc_ok;
    assign opc_ok = (inst[63:61] == 3'b111) && (inst[58:55] == 4'b1000);

    // R5: a rejection pulse follows a GPR-sourced render-target alias
    a_r5_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_rt_src |-> $past(inst_valid && opc_ok && !clr && inst[49] == 1'b0 &&
                             inst[47] == 1'b1 && inst[52:51] == 2'd0));

    // R1: words that are not alias instructions raise no flag
    a_r1_quiet_flags: assert property (@(posedge clk) disable iff (rst)
        $past(!(inst_valid && opc_ok)) |-> (!err_rt_src && !ovf));

    // R8: a rejected entry never also counts as an overflow
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(err_rt_src && ovf));

    // R10: a clear empties every table
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !lk_hit);

    // R11: idle lookup port reads zero
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && lk_value == 32'd0 && lk_kind == 2'd0 && !lk_half));

    // R3: the reported kind is one of the three defined codes
    a_r3_kind_code: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_kind != 2'd3));

    // R4: half operands carry nothing in the upper halfword
    a_r4_half_width: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_half) |-> (lk_value[31:16] == 16'd0));

    // R5: render-target hits are never GPR and never half
    a_r5_rt_hit_form: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_scope == 2'd1) |-> (lk_kind != 2'd0 && !lk_half));

endmodule

bind operand_alias_table oat_checker u_oat_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .inst_valid (inst_valid),
    .inst       (inst),
    .lk_valid   (lk_valid),
    .lk_scope   (lk_scope),
    .lk_hit     (lk_hit),
    .lk_kind    (lk_kind),
    .lk_half    (lk_half),
    .lk_value   (lk_value),
    .err_rt_src (err_rt_src),
    .ovf        (ovf)
);

// File: tb/tb_operand_alias_table.sv
module tb_operand_alias_table;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        inst_valid = 1'b0;
    logic [63:0] inst = '0;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_scope = '0;
    logic [7:0]  lk_reg = '0;
    logic        lk_hit;
    logic [1:0]  lk_kind;
    logic        lk_half;
    logic [31:0] lk_value;
    logic        err_rt_src;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    operand_alias_table dut (
        .clk(clk), .rst(rst), .clr(clr), .inst_valid(inst_valid), .inst(inst),
        .lk_valid(lk_valid), .lk_scope(lk_scope), .lk_reg(lk_reg),
        .lk_hit(lk_hit), .lk_kind(lk_kind), .lk_half(lk_half), .lk_value(lk_value),
        .err_rt_src(err_rt_src), .ovf(ovf)
    );

    // model of the three tables, built from the requirements
    bit          m_vld  [3][16];
    logic [7:0]  m_tag  [3][16];
    logic [1:0]  m_kind [3][16];
    bit          m_half [3][16];
    logic [31:0] m_val  [3][16];
    int          m_cnt  [3];
    int          m_lim  [3];

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sidx(input logic [1:0] code);
        return (code == 2'd0) ? 0 : (code == 2'd1) ? 1 : 2;
    endfunction

    function automatic logic [63:0] mk(input logic [1:0] sc, input logic [1:0] kd, input logic sz,
                                       input logic [7:0] dst, input logic [3:0] m1, input logic [31:0] src);
        logic [63:0] w = '0;
        w[63:61] = 3'b111; w[58:55] = 4'b1000; w[54] = 1'b1;
        w[52:51] = kd; w[50] = sz; w[49] = sc[1]; w[47] = sc[0];
        w[43:40] = m1; w[39:32] = dst; w[31:0] = src;
        return w;
    endfunction

    function automatic logic [35:0] expect_lk(input logic [1:0] sc, input logic [7:0] r);
        int s = sidx(sc);
        for (int i = 0; i < 16; i++)
            if (m_vld[s][i] && m_tag[s][i] == r)
                return {1'b1, m_kind[s][i], m_half[s][i], m_val[s][i]};
        return '0;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 3; s++) begin
            m_cnt[s] = 0; m_lim[s] = 0;
            for (int i = 0; i < 16; i++) m_vld[s][i] = 0;
        end
    endtask

    task automatic look(input logic [1:0] sc, input logic [7:0] r, input string req);
        logic [35:0] e, a;
        lk_valid = 1'b1; lk_scope = sc; lk_reg = r;
        #1;
        e = expect_lk(sc, r);
        a = {lk_hit, lk_kind, lk_half, lk_value};
        chk(a == e, req, a, e);
        lk_valid = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 64; r++) begin
                @(negedge clk);
                look(2'(s), 8'(r), req);
            end
    endtask

    // apply one alias instruction, update the model, check flags and next-cycle visibility
    task automatic alias_op(input logic [1:0] sc, input logic [1:0] kd, input logic sz,
                            input logic [7:0] dst, input logic [3:0] m1, input logic [31:0] src,
                            input string req);
        int s = sidx(sc);
        bit e_err = 0, e_ovf = 0, hit = 0;
        logic [7:0] tag = (s == 1) ? {3'b0, dst[4:0]} : dst;
        bit half = (s != 1) && !sz;
        logic [1:0] k = (kd >= 2) ? 2'd2 : kd;
        logic [31:0] v = (kd == 0) ? {24'b0, src[7:0]} : (kd == 1) ? {21'b0, src[10:0]}
                         : half ? {16'b0, src[15:0]} : src;
        if (s == 1 && kd == 0) e_err = 1;
        else begin
            for (int i = 0; i < 16; i++)
                if (m_vld[s][i] && m_tag[s][i] == tag) begin
                    m_kind[s][i] = k; m_half[s][i] = half; m_val[s][i] = v; hit = 1;
                end
            if (!hit) begin
                if (m_cnt[s] == 0) m_lim[s] = (s == 1) ? 16 : int'(m1) + 1;
                if (m_cnt[s] < m_lim[s]) begin
                    m_vld[s][m_cnt[s]] = 1; m_tag[s][m_cnt[s]] = tag; m_kind[s][m_cnt[s]] = k;
                    m_half[s][m_cnt[s]] = half; m_val[s][m_cnt[s]] = v; m_cnt[s]++;
                end else e_ovf = 1;
            end
        end
        @(negedge clk);
        inst = mk(sc, kd, sz, dst, m1, src); inst_valid = 1'b1;
        @(negedge clk);
        inst_valid = 1'b0; inst = '0;
        chk(err_rt_src == e_err, {req, " err"}, 36'(err_rt_src), 36'(e_err));
        chk(ovf == e_ovf, {req, " ovf"}, 36'(ovf), 36'(e_ovf));
        look(sc, tag, {req, " R7 next-cycle"});
    endtask

    task automatic raw_op(input logic [63:0] w, input logic v, input string req);
        @(negedge clk);
        inst = w; inst_valid = v;
        @(negedge clk);
        inst_valid = 1'b0; inst = '0;
        chk(!err_rt_src && !ovf, req, {34'b0, err_rt_src, ovf}, 36'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(!err_rt_src && !ovf, "R11 reset flags", {34'b0, err_rt_src, ovf}, 36'd0);
        sweep("R11 reset empty");
        @(negedge clk);
        chk(!lk_hit && lk_value == 0, "R11 idle port", {lk_hit, 3'b0, lk_value}, 36'd0);

        // R3 R4 R6 R8: texture group of four
        alias_op(2'd0, 2'd0, 1'b1, 8'd1, 4'd3, 32'hABCD_EF12, "R3 tex gpr");
        alias_op(2'd0, 2'd1, 1'b1, 8'd2, 4'd9, 32'hFFFF_F7A5, "R3 tex const");
        alias_op(2'd0, 2'd2, 1'b0, 8'd3, 4'd9, 32'h1234_5678, "R4 tex half imm");
        alias_op(2'd0, 2'd3, 1'b1, 8'd40, 4'd9, 32'hDEAD_BEEF, "R4 tex full imm");
        alias_op(2'd0, 2'd2, 1'b1, 8'd5, 4'd9, 32'h0000_0005, "R8 tex overflow");
        alias_op(2'd0, 2'd2, 1'b0, 8'd2, 4'd9, 32'hCAFE_0042, "R9 tex overwrite");
        sweep("R6 tex table");

        // R2: memory codes 2 and 3 share one table
        alias_op(2'd2, 2'd0, 1'b0, 8'd1, 4'd1, 32'h0000_0033, "R2 mem code2");
        alias_op(2'd3, 2'd1, 1'b1, 8'd9, 4'd7, 32'h0000_0123, "R2 mem code3");
        alias_op(2'd2, 2'd2, 1'b1, 8'd10, 4'd7, 32'h0000_7777, "R8 mem overflow");
        alias_op(2'd3, 2'd2, 1'b1, 8'd1, 4'd7, 32'h1111_2222, "R9 mem overwrite");
        sweep("R2 scopes");

        // R5: render-target scope
        alias_op(2'd1, 2'd2, 1'b0, 8'h1F, 4'd0, 32'h89AB_CDEF, "R5 rt imm size ignored");
        alias_op(2'd1, 2'd1, 1'b0, 8'hE3, 4'd0, 32'h0000_0456, "R5 rt 5-bit key");
        alias_op(2'd1, 2'd0, 1'b1, 8'd6, 4'd0, 32'h0000_0011, "R5 rt gpr rejected");
        sweep("R5 rt table");

        // R1: non-alias words and invalid cycles
        raw_op(mk(2'd0, 2'd2, 1'b1, 8'd20, 4'd0, 32'h1) & ~(64'h1 << 58), 1'b1, "R1 bad opcode");
        raw_op(mk(2'd0, 2'd2, 1'b1, 8'd21, 4'd0, 32'h1) & ~(64'h1 << 61), 1'b1, "R1 bad class");
        raw_op(mk(2'd2, 2'd2, 1'b1, 8'd22, 4'd0, 32'h1), 1'b0, "R1 not valid");
        raw_op(mk(2'd1, 2'd0, 1'b1, 8'd4, 4'd0, 32'h1), 1'b0, "R1 not valid rt");
        sweep("R1 unchanged");

        // R10: clear with a simultaneous alias
        @(negedge clk);
        clr = 1'b1; inst = mk(2'd0, 2'd2, 1'b1, 8'd30, 4'd0, 32'h9); inst_valid = 1'b1;
        @(negedge clk);
        clr = 1'b0; inst_valid = 1'b0; inst = '0;
        model_clear();
        chk(!err_rt_src && !ovf, "R10 flags", {34'b0, err_rt_src, ovf}, 36'd0);
        sweep("R10 cleared");

        // R8: render-target capacity is the depth
        for (int i = 0; i < 17; i++)
            alias_op(2'd1, 2'd1, 1'b1, 8'(i), 4'd0, 32'(i * 3), "R8 rt fill");
        sweep("R8 rt full");

        // R11: idle lookup while entries exist
        @(negedge clk);
        lk_valid = 1'b0; lk_scope = 2'd1; lk_reg = 8'd0;
        #1;
        chk({lk_hit, lk_kind, lk_half, lk_value} == 36'd0, "R11 lk_valid low",
            {lk_hit, lk_kind, lk_half, lk_value}, 36'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule